// File: doc/BRIEF.md
# Out-of-Band Framed Packet Transmitter

This block sends variable-length packets of bytes through an attached asynchronous UART transmitter. A packet is not delimited by any in-band marker. The block holds an active-low terminal-ready output (`dtr_n`) low for the whole packet and releases it once the packet has fully left the line. Every byte value can therefore appear in the payload. A host supplies the bytes over a valid/ready interface, and a flag marks the final byte. The block passes each byte to the UART with a one-cycle start pulse, then waits for the UART's done strobe before it moves on.

When flow control is enabled, each byte is paced by an active-low clear-to-send input (`cts_n`). A byte that meets an inactive `cts_n` is held and the packet stays open. The block can also append two trailer bytes after the payload: a length byte, then a checksum byte. Both go out while `dtr_n` is still low. After each packet, `dtr_n` stays high for at least a programmable number of cycles before the next packet may begin.

`fields_en`, `fc_en` and `gap_len` are expected to stay constant while a packet is open.

Top module: `pkt_frame_tx`

## Requirements
- R1: During and directly after reset, `dtr_n` is 1, `in_ready` is 0 and `uart_start` is 0.
- R2: Every `uart_start` pulse occurs while `dtr_n` is 0, and `dtr_n` was already 0 in the previous cycle, so the line is marked active before the first byte goes out.
- R3: Payload bytes reach `uart_data` unmodified and in the order they were accepted, including the values 0x00 and 0xFF.
- R4: `uart_start` lasts exactly one cycle. No further `uart_start` is issued until `uart_done` has been seen for the byte in flight.
- R5: With `fc_en`=1, `uart_start` only occurs while `cts_n` is 0. While `cts_n` is 1 the pending byte is held, no byte is issued and `dtr_n` stays 0.
- R6: With `fc_en`=0, the value of `cts_n` has no effect, and bytes are issued while `cts_n` is 1.
- R7: `dtr_n` rises only in the cycle after the `uart_done` of the packet's final byte. It never rises while a byte is still in flight.
- R8: Between the end of one packet and the start of the next, `dtr_n` stays 1 for at least `gap_len` cycles.
- R9: With `fields_en`=1, two bytes follow the last payload byte. The first is the payload length modulo 256. The second is the modulo-256 sum of the payload bytes and the length byte.
- R10: With `fields_en`=0, exactly the payload bytes are sent and nothing else.
- R11: `in_ready` is 1 only while `dtr_n` is 0 and no byte is pending or in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host byte valid |
| in_data | input | 8 | Host byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Block accepts the host byte |
| fields_en | input | 1 | Append length and checksum bytes |
| fc_en | input | 1 | Enable clear-to-send pacing |
| gap_len | input | GAP_W | Minimum inactive cycles between packets |
| cts_n | input | 1 | Clear-to-send, active low |
| dtr_n | output | 1 | Packet-active line, active low |
| uart_start | output | 1 | One-cycle request to send `uart_data` |
| uart_data | output | 8 | Byte for the UART |
| uart_done | input | 1 | UART reports the byte, including its stop bit, has left the shifter |

## Verification
The assertions check the cycle-level rules on every cycle:
- no byte is issued while `dtr_n` is inactive or in its first active cycle;
- no byte is issued against an inactive `cts_n` when pacing is enabled;
- `uart_start` is a single-cycle pulse;
- `in_ready` is high only inside a packet;
- `dtr_n` rises only right after a done strobe;
- the inactive run before each packet is long enough.

The bench's scenarios are needed for the rest. They show that the bytes arrive unmodified and in order, that the length and checksum values are correct (including wrap past 256), and that a held byte is released once `cts_n` returns. They also show that `cts_n` is ignored when pacing is disabled and that no trailer is sent when it is turned off.

// File: rtl/ptx_pkg.sv
// Shared types for the framed packet transmitter.
package ptx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,   // line inactive, waiting for host
        S_FETCH,  // line active, taking next payload byte
        S_ISSUE,  // byte held, waiting for clear-to-send
        S_WAIT,   // byte in flight, waiting for UART done
        S_GAP     // line inactive, enforcing inter-packet gap
    } ptx_state_e;

    typedef enum logic [1:0] {
        K_DATA,
        K_LEN,
        K_SUM
    } ptx_kind_e;
endpackage

// File: rtl/ptx_accum.sv
// Running byte count and sum of one packet's payload.
// Assumes: clr and add_en are never asserted together.
// Output chk is the payload sum plus the count, all modulo 2**W.
module ptx_accum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] chk
);
    logic [W-1:0] sum_q;

    // Track the payload count and sum; clear at packet start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt   <= '0;
            sum_q <= '0;
        end else if (add_en) begin
            cnt   <= cnt + 1'b1;
            sum_q <= sum_q + add_val;
        end
    end

    // The checksum folds the length byte into the payload sum.
    always_comb chk = sum_q + cnt;
endmodule

// File: rtl/ptx_gap_timer.sv
// Counts the cycles spent in the inter-packet gap.
// Assumes: clr is pulsed once as the gap begins; tick is high for each gap cycle.
// expired is high once the count has reached gap_len.
module ptx_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [GAP_W-1:0] gap_len,
    output logic             expired
);
    logic [GAP_W-1:0] cnt_q;

    // Saturating count of gap cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (tick && cnt_q != {GAP_W{1'b1}})
            cnt_q <= cnt_q + 1'b1;
    end

    // Expiry compare.
    always_comb expired = (cnt_q >= gap_len);
endmodule

// File: rtl/ptx_ctrl.sv
// Packet framing controller: opens the line, fetches and holds bytes,
// paces them with clear-to-send, appends optional trailer bytes and
// closes the line after the last UART done.
// Assumes: the UART raises uart_done once for each uart_start, at least one cycle later.
module ptx_ctrl
    import ptx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    output logic         in_ready,
    input  logic         fields_en,
    input  logic         fc_en,
    input  logic         cts_n,
    input  logic         uart_done,
    input  logic         gap_expired,
    input  logic [W-1:0] acc_cnt,
    input  logic [W-1:0] acc_chk,
    output logic         dtr_n,
    output logic         uart_start,
    output logic [W-1:0] uart_data,
    output logic         acc_clr,
    output logic         acc_add,
    output logic         gap_clr,
    output logic         gap_tick
);
    ptx_state_e state_q, state_d;
    ptx_kind_e  kind_q;
    logic       last_q;
    logic [W-1:0] hold_q;
    logic       cts_ok;

    // Line permission for handing a byte to the UART.
    always_comb cts_ok = !fc_en || !cts_n;

    // Next-state and strobe decode.
    always_comb begin
        state_d    = state_q;
        in_ready   = 1'b0;
        uart_start = 1'b0;
        acc_clr    = 1'b0;
        acc_add    = 1'b0;
        gap_clr    = 1'b0;
        gap_tick   = 1'b0;
        unique case (state_q)
            S_IDLE: if (in_valid) begin
                state_d = S_FETCH;
                acc_clr = 1'b1;
            end
            S_FETCH: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    acc_add = 1'b1;
                    state_d = S_ISSUE;
                end
            end
            S_ISSUE: if (cts_ok) begin
                uart_start = 1'b1;
                state_d    = S_WAIT;
            end
            S_WAIT: if (uart_done) begin
                if (kind_q == K_DATA && !last_q)
                    state_d = S_FETCH;
                else if ((kind_q == K_DATA && fields_en) || kind_q == K_LEN)
                    state_d = S_ISSUE;
                else begin
                    state_d = S_GAP;
                    gap_clr = 1'b1;
                end
            end
            S_GAP: begin
                gap_tick = 1'b1;
                if (gap_expired) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Held byte, its kind and the last-byte flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            kind_q <= K_DATA;
            last_q <= 1'b0;
        end else if (state_q == S_FETCH && in_valid) begin
            hold_q <= in_data;
            kind_q <= K_DATA;
            last_q <= in_last;
        end else if (state_q == S_WAIT && uart_done) begin
            if (kind_q == K_DATA && last_q && fields_en) begin
                hold_q <= acc_cnt;
                kind_q <= K_LEN;
            end else if (kind_q == K_LEN) begin
                hold_q <= acc_chk;
                kind_q <= K_SUM;
            end
        end
    end

    // Line marking and UART byte.
    always_comb begin
        dtr_n     = (state_q == S_IDLE) || (state_q == S_GAP);
        uart_data = hold_q;
    end

    // R2
    start_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uart_start |-> (!dtr_n && !$past(dtr_n)));
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uart_start |=> !uart_start);
    // R5
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_start && fc_en) |-> !cts_n);
    // R5
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ISSUE && fc_en && cts_n) |=> (!dtr_n && $stable(uart_data)));
    // R11
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !dtr_n);
endmodule

// File: rtl/pkt_frame_tx.sv
// Top of the framed packet transmitter: ties together the controller,
// the count/checksum accumulator and the gap timer.
// Assumes: fields_en, fc_en and gap_len stay constant while a packet is open.
module pkt_frame_tx
    import ptx_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              fields_en,
    input  logic              fc_en,
    input  logic [GAP_W-1:0]  gap_len,
    input  logic              cts_n,
    output logic              dtr_n,
    output logic              uart_start,
    output logic [BYTE_W-1:0] uart_data,
    input  logic              uart_done
);
    logic              acc_clr, acc_add, gap_clr, gap_tick, gap_expired;
    logic [BYTE_W-1:0] acc_cnt, acc_chk;

    ptx_ctrl #(.W(BYTE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .fields_en(fields_en), .fc_en(fc_en), .cts_n(cts_n),
        .uart_done(uart_done), .gap_expired(gap_expired),
        .acc_cnt(acc_cnt), .acc_chk(acc_chk),
        .dtr_n(dtr_n), .uart_start(uart_start), .uart_data(uart_data),
        .acc_clr(acc_clr), .acc_add(acc_add), .gap_clr(gap_clr), .gap_tick(gap_tick)
    );

    ptx_accum #(.W(BYTE_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add_en(acc_add),
        .add_val(in_data), .cnt(acc_cnt), .chk(acc_chk)
    );

    ptx_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(gap_clr), .tick(gap_tick),
        .gap_len(gap_len), .expired(gap_expired)
    );

    // Checker state: saturating run length of the inactive line.
    logic [GAP_W:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            hi_run_q <= '1;
        else if (!dtr_n)       hi_run_q <= '0;
        else if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
    end

    // R7
    close_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtr_n) |-> $past(uart_done));
    // R8
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtr_n) |-> (hi_run_q >= {1'b0, gap_len}));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (dtr_n && !in_ready && !uart_start));
endmodule

// File: tb/tb_pkt_frame_tx.sv
module tb_pkt_frame_tx;
    localparam int GAP_W = 8;
    localparam int LAT   = 8;
    localparam logic [GAP_W-1:0] GAP = 8'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [7:0] in_data = 8'h00;
    logic fields_en = 1'b0, fc_en = 1'b0, cts_n = 1'b0;
    logic [GAP_W-1:0] gap_len = GAP;
    logic dtr_n, uart_start, uart_done;
    logic [7:0] uart_data;

    always #2.5 clk = ~clk;

    pkt_frame_tx #(.GAP_W(GAP_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .fields_en(fields_en),
        .fc_en(fc_en), .gap_len(gap_len), .cts_n(cts_n), .dtr_n(dtr_n),
        .uart_start(uart_start), .uart_data(uart_data), .uart_done(uart_done)
    );

    int checks = 0, errors = 0;
    logic [7:0] pkt [300];
    logic [7:0] cap [300];
    int ncap = 0;
    int bad_dtr = 0, bad_cts = 0, bad_overlap = 0, bad_early = 0, cts_high_starts = 0;
    int hi_cnt = 0, last_hi = 0;
    logic busy = 1'b0, dtr_prev = 1'b1;
    int lat_cnt = 0;

    // UART model and line monitor.
    always @(posedge clk) begin
        uart_done <= 1'b0;
        if (!rst_n) begin
            busy <= 1'b0;
        end else begin
            if (uart_start) begin
                cap[ncap] = uart_data;
                ncap++;
                if (dtr_n) bad_dtr++;
                if (fc_en && cts_n) bad_cts++;
                if (cts_n) cts_high_starts++;
                if (busy) bad_overlap++;
                busy <= 1'b1;
                lat_cnt = LAT;
            end else if (busy) begin
                lat_cnt--;
                if (lat_cnt == 1) begin
                    uart_done <= 1'b1;
                    busy <= 1'b0;
                end
            end
            if (dtr_n && !dtr_prev && busy) bad_early++;
            if (dtr_n) hi_cnt++;
            else begin
                if (dtr_prev) last_hi = hi_cnt;
                hi_cnt = 0;
            end
        end
        dtr_prev = dtr_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_pkt(input int n);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = pkt[i];
            in_last  = (i == n - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_end();
        while (!dtr_n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_frame(input int n, input bit fields, input string req);
        logic [7:0] s;
        int mism;
        s = 8'h00;
        mism = 0;
        check(ncap == n + (fields ? 2 : 0), req, ncap, n + (fields ? 2 : 0));
        for (int i = 0; i < n; i++) begin
            s = s + pkt[i];
            if (cap[i] !== pkt[i]) mism++;
        end
        check(mism == 0, "R3 payload bytes", mism, 0);
        if (fields) begin
            check(cap[n] == 8'(n), "R9 length byte", cap[n], n % 256);
            check(cap[n+1] == 8'(s + 8'(n)), "R9 checksum byte", cap[n+1], 8'(s + 8'(n)));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(dtr_n == 1'b1, "R1 dtr_n", dtr_n, 1);
        check(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
        check(uart_start == 1'b0, "R1 uart_start", uart_start, 0);
    endtask

    task automatic t_plain();   // R3 R10
        pkt[0] = 8'h00; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'h0D;
        fields_en = 1'b0; ncap = 0;
        send_pkt(4); wait_end();
        check_frame(4, 1'b0, "R10 byte count");
        check(dtr_n == 1'b1, "R7 line closed", dtr_n, 1);
    endtask

    task automatic t_fields();  // R9
        for (int i = 0; i < 5; i++) pkt[i] = 8'(8'hF0 + i * 7);
        fields_en = 1'b1; ncap = 0;
        send_pkt(5); wait_end();
        check_frame(5, 1'b1, "R9 byte count");
        pkt[0] = 8'hFF; ncap = 0;
        send_pkt(1); wait_end();
        check_frame(1, 1'b1, "R9 single byte count");
    endtask

    task automatic t_wrap();    // R9 length wrap
        for (int i = 0; i < 258; i++) pkt[i] = 8'(i * 13 + 5);
        fields_en = 1'b1; ncap = 0;
        send_pkt(258); wait_end();
        check_frame(258, 1'b1, "R9 wrap count");
    endtask

    task automatic t_cts();     // R5
        pkt[0] = 8'h11; pkt[1] = 8'h22;
        fields_en = 1'b0; fc_en = 1'b1; cts_n = 1'b1; ncap = 0;
        fork
            send_pkt(2);
            begin
                repeat (20) @(negedge clk);
                check(ncap == 0, "R5 held while cts high", ncap, 0);
                check(dtr_n == 1'b0, "R5 line stays active", dtr_n, 0);
                cts_n = 1'b0;
            end
        join
        wait_end();
        check_frame(2, 1'b0, "R5 count after release");
        check(bad_cts == 0, "R5 starts against cts", bad_cts, 0);
        fc_en = 1'b0;
    endtask

    task automatic t_fc_off();  // R6
        pkt[0] = 8'hA5; pkt[1] = 8'h5A; pkt[2] = 8'h3C;
        fields_en = 1'b0; fc_en = 1'b0; cts_n = 1'b1; ncap = 0; cts_high_starts = 0;
        send_pkt(3); wait_end();
        check_frame(3, 1'b0, "R6 count with cts ignored");
        check(cts_high_starts == 3, "R6 starts while cts high", cts_high_starts, 3);
        cts_n = 1'b0;
    endtask

    task automatic t_gap();     // R8
        pkt[0] = 8'h01; pkt[1] = 8'h02;
        fields_en = 1'b0; ncap = 0;
        send_pkt(2);
        send_pkt(2);
        wait_end();
        check(last_hi >= GAP, "R8 minimum gap", last_hi, GAP);
        check(last_hi <= GAP + 3, "R8 gap not excessive", last_hi, GAP + 3);
        check(ncap == 4, "R8 both packets sent", ncap, 4);
    endtask

    task automatic t_rules();   // R2 R4 R7
        check(bad_dtr == 0, "R2 start with line inactive", bad_dtr, 0);
        check(bad_overlap == 0, "R4 start while busy", bad_overlap, 0);
        check(bad_early == 0, "R7 close while busy", bad_early, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_fields();
        t_wrap();
        t_cts();
        t_fc_off();
        t_gap();
        t_rules();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule